// File: doc/BRIEF.md
# Clock Source Select Controller

This block decides which of two clock sources paces the system clock output of a chip, and how that choice behaves when the chip enters its wait and stop low-power modes. Both sources arrive as single-cycle tick strobes inside one synchronous clock domain: a crystal tick and a tick from a frequency synthesizer (a phase-locked loop). The block divides the chosen tick by two and presents it as a one-cycle enable. It also passes the crystal tick through as a buffered enable, raises an interrupt pulse when the effective lock state of the synthesizer changes, and drives the synthesizer's power-on control.

Software controls the block through a two-bit control word. Bit 0 turns the synthesizer on and bit 1 selects it as the base clock. The two bits are independent. A source change only takes effect at a divided-output boundary, and the incoming divider restarts when it does. A stop request silences every output, drops the synthesizer selection in hardware, and lets the system resume from the crystal. A wait request leaves everything running.

Top module: `clk_src_sel`

## Requirements
- R1: All outputs are registered, with one cycle of latency. When the active source is the crystal, `sys_en_o` pulses on every second `xtal_tick`. When it is the synthesizer, `sys_en_o` pulses on every second `vco_tick`. The synthesizer is the target source when control bit 1 (select) and bit 0 (PLL on) are both 1.
- R2: A write (`wr_en`=1) outside stop loads `wr_data` into the control word whatever the value of `pll_locked`. `rd_data_o` returns the word on the next cycle, with bit 1 = select and bit 0 = PLL on.
- R3: `wait_req` has no effect on any output.
- R4: `pll_on_o` equals control bit 0. It changes only through a write, independently of the select bit and of stop.
- R5: In every cycle after a cycle with `stop_req` high, `sys_en_o`, `xtal_en_o` and `irq_o` are low.
- R6: While `stop_req` is high, the select bit is cleared, and a write cannot set it.
- R7: After stop ends, the output runs from the crystal divided by two. The select bit reads 0 until software writes it.
- R8: A source change happens only in a cycle where the current source emits its divided pulse, and the incoming divider is restarted at that point. As a result, `sys_en_o` is never high in two consecutive cycles.
- R9: While the PLL-on bit is 0, the output runs from the crystal even if the select bit reads 1, the synthesizer divider is held cleared, and `pll_locked` is treated as 0.
- R10: Reset clears both control bits and every output, so the block starts from the crystal divided by two.
- R11: `irq_o` pulses for one cycle each time the effective lock (`pll_locked` AND PLL-on) differs from its value in the previous cycle. The pulse is suppressed in stop.
- R12: `xtal_en_o` repeats `xtal_tick` one cycle later, except while in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | Crystal clock tick strobe |
| vco_tick | input | 1 | Synthesizer clock tick strobe |
| pll_locked | input | 1 | Synthesizer lock indicator |
| stop_req | input | 1 | Stop mode request |
| wait_req | input | 1 | Wait mode request |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 2 | Control word write data (bit 1 select, bit 0 PLL on) |
| rd_data_o | output | 2 | Control word read-back |
| sys_en_o | output | 1 | Selected divided clock enable |
| xtal_en_o | output | 1 | Buffered crystal clock enable |
| irq_o | output | 1 | Lock-change interrupt pulse |
| pll_on_o | output | 1 | Synthesizer power-on control |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around its rising edge. They also assume that the tick inputs are plain strobes with no minimum spacing, and that reset is applied before the first meaningful cycle. The stimulus drives all inputs on the falling edge only. It sets tick densities and lock toggling at random with a fixed seed. Stop requests come in bursts of several cycles, and writes can fall inside a stop burst, so the hardware-clear path contends with software.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
    localparam int CTRL_W    = 2;
    localparam int PLLON_BIT = 0;
    localparam int SEL_BIT   = 1;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_VCO  = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_WAIT = 2'd1,
        MODE_STOP = 2'd2
    } pmode_e;

    typedef struct packed {
        logic sel;
        logic pll_on;
    } ctrl_t;

    typedef struct packed {
        src_e src;
        logic lock;
        logic sys_en;
        logic xtal_en;
        logic irq;
    } path_t;
endpackage

// File: rtl/clk_half_div.sv
module clk_half_div #(
    parameter int DIV_LOG2 = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic pulse
);
    localparam int            CW   = DIV_LOG2;
    localparam logic [CW-1:0] LAST = '1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // the last tick of each group of 2**DIV_LOG2 ticks marks the boundary
    assign pulse = tick & (cnt_q == LAST);
endmodule

// File: rtl/csel_ctrl_regs.sv
module csel_ctrl_regs
    import clk_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.sel    = wr_data[SEL_BIT];
            ctrl_d.pll_on = wr_data[PLLON_BIT];
        end
        // the hardware clear in stop wins over any software write
        if (halted) begin
            ctrl_d.sel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
    import clk_src_pkg::*;
#(
    parameter int DIV_LOG2 = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_tick,
    input  logic       vco_tick,
    input  logic       pll_locked,
    input  logic       stop_req,
    input  logic       wait_req,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic [1:0] rd_data_o,
    output logic       sys_en_o,
    output logic       xtal_en_o,
    output logic       irq_o,
    output logic       pll_on_o
);
    pmode_e mode;
    logic   halted;
    ctrl_t  ctrl;
    path_t  path_d, path_q;
    logic   xtal_pulse, vco_pulse;
    logic   xtal_clr, vco_clr;
    logic   lock_eff, cur_pulse, switching;
    src_e   want_src;

    // stop takes priority over wait; wait keeps everything running
    always_comb begin
        if (stop_req) begin
            mode = MODE_STOP;
        end else if (wait_req) begin
            mode = MODE_WAIT;
        end else begin
            mode = MODE_RUN;
        end
    end
    assign halted = (mode == MODE_STOP);

    csel_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .halted  (halted),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_o  (ctrl)
    );

    clk_half_div #(.DIV_LOG2(DIV_LOG2)) u_xdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (xtal_clr),
        .tick  (xtal_tick),
        .pulse (xtal_pulse)
    );

    clk_half_div #(.DIV_LOG2(DIV_LOG2)) u_vdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (vco_clr),
        .tick  (vco_tick),
        .pulse (vco_pulse)
    );

    always_comb begin
        lock_eff  = ctrl.pll_on & pll_locked;
        want_src  = (ctrl.sel & ctrl.pll_on) ? SRC_VCO : SRC_XTAL;
        cur_pulse = (path_q.src == SRC_VCO) ? vco_pulse : xtal_pulse;

        path_d = path_q;
        if (halted || !ctrl.pll_on) begin
            path_d.src = SRC_XTAL;
        end else if (cur_pulse) begin
            path_d.src = want_src;
        end
        switching = (path_d.src != path_q.src);

        // the incoming divider restarts so its first pulse is a full period away
        xtal_clr = halted | (switching & (path_d.src == SRC_XTAL));
        vco_clr  = halted | ~ctrl.pll_on | (switching & (path_d.src == SRC_VCO));

        path_d.lock    = lock_eff;
        path_d.sys_en  = ~halted & cur_pulse;
        path_d.xtal_en = ~halted & xtal_tick;
        path_d.irq     = ~halted & (lock_eff ^ path_q.lock);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q <= '{src: SRC_XTAL, default: 1'b0};
        end else begin
            path_q <= path_d;
        end
    end

    assign sys_en_o  = path_q.sys_en;
    assign xtal_en_o = path_q.xtal_en;
    assign irq_o     = path_q.irq;
    assign pll_on_o  = ctrl.pll_on;
    assign rd_data_o = {ctrl.sel, ctrl.pll_on};
endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk
    import clk_src_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       xtal_tick,
    input logic       vco_tick,
    input logic       pll_locked,
    input logic       stop_req,
    input logic       wait_req,
    input logic       wr_en,
    input logic [1:0] wr_data,
    input logic [1:0] rd_data_o,
    input logic       sys_en_o,
    input logic       xtal_en_o,
    input logic       irq_o,
    input logic       pll_on_o
);
    p_sys_from_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en_o |-> $past(xtal_tick | vco_tick));

    p_write_unblocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stop_req) |=> (rd_data_o == $past(wr_data)));

    p_pll_on_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pll_on_o));

    p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!sys_en_o && !xtal_en_o && !irq_o));

    p_stop_clears_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !rd_data_o[SEL_BIT]);

    p_sel_stays_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_data_o[SEL_BIT]) |=> !rd_data_o[SEL_BIT]);

    p_no_short_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en_o |=> !sys_en_o);

    p_irq_not_in_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !$past(stop_req));

    p_xtal_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_en_o |-> ($past(xtal_tick) && !$past(stop_req)));

    // wait_req and pll_locked are observed only through the top's behaviour
    logic unused_ok;
    assign unused_ok = wait_req ^ pll_locked;
endmodule

bind clk_src_sel clk_src_sel_chk u_chk (.*);

// File: tb/sim_clk_src_sel.sv
module sim_clk_src_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_tick = 1'b0, vco_tick = 1'b0, pll_locked = 1'b0;
    logic       stop_req = 1'b0, wait_req = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic [1:0] rd_data_o;
    logic       sys_en_o, xtal_en_o, irq_o, pll_on_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string tag = "R10";
    logic  prev_sys = 1'b0;

    always #10 clk = ~clk;

    clk_src_sel u0 (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .vco_tick(vco_tick),
        .pll_locked(pll_locked), .stop_req(stop_req), .wait_req(wait_req),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data_o(rd_data_o),
        .sys_en_o(sys_en_o), .xtal_en_o(xtal_en_o), .irq_o(irq_o), .pll_on_o(pll_on_o)
    );

    // reference model built from the requirements (divide by two)
    logic m_sel, m_pll, m_src, m_lock, m_sys, m_xen, m_irq, m_xc, m_vc;
    always @(posedge clk or negedge rst_n) begin : model
        logic lk, xp, vp, cur, nsrc, sw;
        if (!rst_n) begin
            m_sel <= 0; m_pll <= 0; m_src <= 0; m_lock <= 0;
            m_sys <= 0; m_xen <= 0; m_irq <= 0; m_xc <= 0; m_vc <= 0;
        end else begin
            lk   = m_pll & pll_locked;
            xp   = xtal_tick & m_xc;
            vp   = vco_tick & m_vc;
            cur  = m_src ? vp : xp;
            nsrc = m_src;
            if (stop_req || !m_pll) nsrc = 1'b0;
            else if (cur) nsrc = m_sel & m_pll;
            sw = (nsrc != m_src);
            m_xc  <= (stop_req || (sw && !nsrc)) ? 1'b0 : (xtal_tick ? ~m_xc : m_xc);
            m_vc  <= (stop_req || !m_pll || (sw && nsrc)) ? 1'b0 : (vco_tick ? ~m_vc : m_vc);
            m_src <= nsrc;
            m_sys <= !stop_req & cur;
            m_xen <= !stop_req & xtal_tick;
            m_irq <= !stop_req & (lk ^ m_lock);
            m_lock <= lk;
            m_sel <= stop_req ? 1'b0 : (wr_en ? wr_data[1] : m_sel);
            m_pll <= wr_en ? wr_data[0] : m_pll;
        end
    end

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s (%s) %s actual=%b expected=%b at %0t", req, tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1",  "sys_en_o",  {1'b0, sys_en_o},  {1'b0, m_sys});
        chk("R12", "xtal_en_o", {1'b0, xtal_en_o}, {1'b0, m_xen});
        chk("R11", "irq_o",     {1'b0, irq_o},     {1'b0, m_irq});
        chk("R2",  "rd_data_o", rd_data_o,         {m_sel, m_pll});
        chk("R4",  "pll_on_o",  {1'b0, pll_on_o},  {1'b0, m_pll});
        chk("R8",  "consecutive sys_en", {1'b0, prev_sys & sys_en_o}, 2'b00);
        prev_sys = sys_en_o;
    endtask

    task automatic cyc(input logic xt, input logic vt, input logic lk, input logic st,
                       input logic wt, input logic we, input logic [1:0] wd);
        @(negedge clk);
        compare();
        xtal_tick = xt; vco_tick = vt; pll_locked = lk;
        stop_req = st; wait_req = wt; wr_en = we; wr_data = wd;
    endtask

    function automatic logic pct(input int p);
        return ($urandom % 100) < p;
    endfunction

    task automatic rnd_run(input int n, input logic st, input logic wt, input int wr_pct);
        for (int i = 0; i < n; i++) begin
            cyc(pct(50), pct(75), pct(90), st, wt, pct(wr_pct), 2'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R10";
        cyc(0, 0, 0, 0, 0, 0, 2'b00);     // reset state compared here
        cyc(0, 0, 0, 0, 0, 0, 2'b00);
        // R2: select and PLL on written while unlocked
        tag = "R2";
        cyc(0, 0, 0, 0, 0, 1, 2'b11);
        cyc(0, 0, 0, 0, 0, 0, 2'b00);
        chk("R2", "readback after unlocked write", rd_data_o, 2'b11);
        // R1: synthesizer drives output with steady vco ticks
        tag = "R1";
        for (int i = 0; i < 40; i++) cyc(pct(50), 1, 1, 0, 0, 0, 2'b00);
        // R5/R6: stop with a write attempting to set select
        tag = "R5_R6";
        for (int i = 0; i < 12; i++) cyc(1, 1, 1, 1, 0, (i == 5), 2'b11);
        @(negedge clk);
        chk("R6", "select after stop", {1'b0, rd_data_o[1]}, 2'b00);
        chk("R5", "outputs in stop", {sys_en_o, irq_o}, 2'b00);
        // R7: recovery from crystal
        tag = "R7";
        for (int i = 0; i < 30; i++) cyc(pct(50), 1, 1, 0, 0, 0, 2'b00);
        chk("R7", "select stays clear", {1'b0, rd_data_o[1]}, 2'b00);
        // R9: select set but PLL off
        tag = "R9";
        cyc(0, 0, 1, 0, 0, 1, 2'b10);
        for (int i = 0; i < 40; i++) cyc(pct(50), 1, 1, 0, 0, 0, 2'b00);
        // R8: repeated switching between sources
        tag = "R8";
        for (int i = 0; i < 200; i++) cyc(pct(60), pct(80), 1, 0, 0, pct(15), 2'($urandom));
        // R3: wait held high while running
        tag = "R3";
        cyc(0, 0, 1, 0, 1, 1, 2'b11);
        rnd_run(300, 0, 1, 5);
        // R11: lock toggling with PLL on
        tag = "R11";
        cyc(0, 0, 0, 0, 0, 1, 2'b01);
        for (int i = 0; i < 60; i++) cyc(pct(50), pct(50), pct(50), 0, 0, 0, 2'b00);
        // random mix with stop bursts
        tag = "RND";
        for (int b = 0; b < 60; b++) begin
            rnd_run(40 + ($urandom % 40), 0, pct(30), 8);
            rnd_run(3 + ($urandom % 10), 1, pct(30), 8);
        end
        @(negedge clk);
        compare();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule